// File: doc/BRIEF.md
# Classification Job Dispatcher

This block sits between a host and a bank of classification processing elements (PEs). The host writes the fields of a job one register at a time over a simple memory-mapped write port. The fields are the splitter-array base address, the key-array base address, the oracle-buffer base address and the key count. These writes only fill staging registers. A final "go" write carries a job tag and commits the staged fields, together with that tag, as one descriptor into a job queue.

Whenever the queue holds a job and at least one PE is idle, the block takes the oldest job from the queue. It hands the job to the lowest-numbered idle PE with a one-cycle start pulse and marks that PE busy. When a PE signals completion, the block places a tagged completion record, holding the job tag and the PE number, into a completion queue. The host drains that queue by polling.

A "go" write that finds the job queue full is dropped, and a sticky overflow flag is raised.

Top module: `job_dispatch`

## Requirements
- R1: Writes with `wr_sel` 0 (splitter address), 1 (key address), 2 (oracle address) or 3 (key count) only update staging registers; they never queue or start a job.
- R2: A write with `wr_sel` 4 ("go") queues the staged fields plus tag `wr_data[TAG_W-1:0]`. With an idle PE, `pe_start` rises in the second cycle after the go write's clock edge, for exactly one cycle, with the job's fields on the `pe_*` descriptor outputs in that cycle.
- R3: A go write while the job queue holds `JOB_DEPTH` jobs is discarded and sets `ovf_flag`, which stays set until reset.
- R4: Among idle PEs, the lowest-numbered one receives the job, and at most one `pe_start` bit is high in any cycle.
- R5: A PE is busy (`pe_busy` bit high) from its start pulse until its completion record is queued, and it receives no start while busy.
- R6: A `pe_done` pulse from a busy PE produces a completion record (`done_tag`, `done_pe`) at the head of the completion queue two cycles later. Records appear in finishing order, with the lower PE first when several finish in one cycle. `done_pop` removes the head record.
- R7: A `pe_done` pulse from an idle PE is ignored.
- R8: Jobs are issued to PEs in the order of their go writes.
- R9: After reset no PE is busy, no start is pending, the completion queue is empty and `ovf_flag` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 3 | Register select (0..3 fields, 4 go) |
| wr_data | input | DATA_W | Write data |
| ovf_flag | output | 1 | Sticky job-queue overflow |
| pe_start | output | NUM_PE | One-cycle start pulse per PE |
| pe_split_addr | output | ADDR_W | Splitter base address of started job |
| pe_key_addr | output | ADDR_W | Key base address of started job |
| pe_oracle_addr | output | ADDR_W | Oracle buffer address of started job |
| pe_key_count | output | CNT_W | Key count of started job |
| pe_done | input | NUM_PE | One-cycle completion pulse per PE |
| pe_busy | output | NUM_PE | Busy state per PE |
| done_valid | output | 1 | Completion queue not empty |
| done_tag | output | TAG_W | Tag of head completion record |
| done_pe | output | PEW | PE index of head completion record |
| done_pop | input | 1 | Remove head completion record |

## Verification
The checker assumes that reset is asserted from time zero. It also assumes that `pe_start` is the only path by which a PE becomes busy, so its rules compare each start against the busy vector of the cycle before. The stimulus pulses `pe_done` for a single cycle and raises `done_pop` only while a record is present. It drives every input on the falling edge, which keeps the dispatch decision a clean function of the state at the rising edge. Completions are issued both one at a time and two at once, so the same-cycle ordering rule is exercised without overfilling the completion queue.

// File: rtl/job_dispatch_pkg.sv
package job_dispatch_pkg;
   localparam int SEL_W = 3;

   typedef enum logic [SEL_W-1:0] {
      SEL_SPLIT  = 3'd0,
      SEL_KEYS   = 3'd1,
      SEL_ORACLE = 3'd2,
      SEL_COUNT  = 3'd3,
      SEL_GO     = 3'd4
   } reg_sel_e;
endpackage

// File: rtl/disp_fifo.sv
module disp_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("disp_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
         if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
         cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end
endmodule

// File: rtl/disp_pick.sv
module disp_pick #(
   parameter int N  = 6,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] idx
);
   logic [N:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign gnt[i]    = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (gnt[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/job_dispatch.sv
module job_dispatch
   import job_dispatch_pkg::*;
#(
   parameter int NUM_PE     = 6,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 24,
   parameter int TAG_W      = 8,
   parameter int JOB_DEPTH  = 4,
   parameter int DONE_DEPTH = 4,
   parameter int PEW        = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic              ovf_flag,
   output logic [NUM_PE-1:0] pe_start,
   output logic [ADDR_W-1:0] pe_split_addr,
   output logic [ADDR_W-1:0] pe_key_addr,
   output logic [ADDR_W-1:0] pe_oracle_addr,
   output logic [CNT_W-1:0]  pe_key_count,
   input  logic [NUM_PE-1:0] pe_done,
   output logic [NUM_PE-1:0] pe_busy,
   output logic              done_valid,
   output logic [TAG_W-1:0]  done_tag,
   output logic [PEW-1:0]    done_pe,
   input  logic              done_pop
);
   localparam int DESC_W = 3 * ADDR_W + CNT_W + TAG_W;
   localparam int DONE_W = TAG_W + PEW;

   if (ADDR_W > DATA_W || CNT_W > DATA_W || TAG_W > DATA_W) begin : g_bad_width
      $error("job_dispatch: field wider than write port");
   end
   if (NUM_PE < 1) begin : g_bad_pe
      $error("job_dispatch: NUM_PE must be positive");
   end

   // staging registers
   logic [ADDR_W-1:0] stg_split, stg_keys, stg_oracle;
   logic [CNT_W-1:0]  stg_count;
   logic              go_wr;

   assign go_wr = wr_en && (wr_sel == SEL_GO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_split  <= '0;
         stg_keys   <= '0;
         stg_oracle <= '0;
         stg_count  <= '0;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_SPLIT:  stg_split  <= wr_data[ADDR_W-1:0];
            SEL_KEYS:   stg_keys   <= wr_data[ADDR_W-1:0];
            SEL_ORACLE: stg_oracle <= wr_data[ADDR_W-1:0];
            SEL_COUNT:  stg_count  <= wr_data[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   // job queue
   logic              jq_empty, jq_full, jq_pop;
   logic [DESC_W-1:0] jq_dout;
   logic [ADDR_W-1:0] h_split, h_keys, h_oracle;
   logic [CNT_W-1:0]  h_count;
   logic [TAG_W-1:0]  h_tag;

   disp_fifo #(.W(DESC_W), .DEPTH(JOB_DEPTH)) i_job_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (go_wr && !jq_full),
      .din   ({stg_split, stg_keys, stg_oracle, stg_count, wr_data[TAG_W-1:0]}),
      .pop   (jq_pop),
      .dout  (jq_dout),
      .empty (jq_empty),
      .full  (jq_full)
   );

   assign {h_split, h_keys, h_oracle, h_count, h_tag} = jq_dout;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ovf_flag <= 1'b0;
      else if (go_wr && jq_full) ovf_flag <= 1'b1;
   end

   // issue to lowest idle PE
   logic [NUM_PE-1:0] busy_q, fin_pend, iss_gnt, fin_gnt;
   logic [PEW-1:0]    iss_idx, fin_idx;
   logic [TAG_W-1:0]  tag_r [NUM_PE];
   logic              dq_full, dq_empty, fin_push;

   disp_pick #(.N(NUM_PE), .IW(PEW)) i_iss_pick (
      .req (~busy_q & {NUM_PE{!jq_empty}}),
      .gnt (iss_gnt),
      .idx (iss_idx)
   );

   assign jq_pop = |iss_gnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pe_start       <= '0;
         pe_split_addr  <= '0;
         pe_key_addr    <= '0;
         pe_oracle_addr <= '0;
         pe_key_count   <= '0;
         for (int i = 0; i < NUM_PE; i++) tag_r[i] <= '0;
      end else begin
         pe_start <= iss_gnt;
         if (jq_pop) begin
            pe_split_addr    <= h_split;
            pe_key_addr      <= h_keys;
            pe_oracle_addr   <= h_oracle;
            pe_key_count     <= h_count;
            tag_r[iss_idx]   <= h_tag;
         end
      end
   end

   // completion tracking
   disp_pick #(.N(NUM_PE), .IW(PEW)) i_fin_pick (
      .req (fin_pend & {NUM_PE{!dq_full}}),
      .gnt (fin_gnt),
      .idx (fin_idx)
   );

   assign fin_push = |fin_gnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= '0;
         fin_pend <= '0;
      end else begin
         busy_q   <= (busy_q | iss_gnt) & ~fin_gnt;
         fin_pend <= (fin_pend | (pe_done & busy_q)) & ~fin_gnt;
      end
   end

   assign pe_busy = busy_q;

   logic [DONE_W-1:0] dq_dout;

   disp_fifo #(.W(DONE_W), .DEPTH(DONE_DEPTH)) i_done_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (fin_push),
      .din   ({tag_r[fin_idx], fin_idx}),
      .pop   (done_pop),
      .dout  (dq_dout),
      .empty (dq_empty),
      .full  (dq_full)
   );

   assign done_valid        = !dq_empty;
   assign {done_tag, done_pe} = dq_dout;
endmodule

// File: rtl/job_dispatch_chk.sv
module job_dispatch_chk #(
   parameter int NUM_PE = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_PE-1:0] pe_start,
   input logic [NUM_PE-1:0] pe_busy,
   input logic              ovf_flag,
   input logic              done_valid,
   input logic              done_pop
);
   localparam logic [NUM_PE-1:0] ONE = NUM_PE'(1);

   assert_one_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pe_start));

   assert_lowest_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_start != '0) |-> (((pe_start - ONE) & ~$past(pe_busy)) == '0));

   assert_no_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_start & $past(pe_busy)) == '0);

   assert_busy_on_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_start & ~pe_busy) == '0);

   assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag |=> ovf_flag);

   assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !done_pop) |=> done_valid);
endmodule

bind job_dispatch job_dispatch_chk #(.NUM_PE(NUM_PE)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pe_start   (pe_start),
   .pe_busy    (pe_busy),
   .ovf_flag   (ovf_flag),
   .done_valid (done_valid),
   .done_pop   (done_pop)
);

// File: tb/test_job_dispatch.sv
`timescale 1ns/1ps
module test_job_dispatch;
   localparam int NPE = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic        ovf_flag;
   logic [NPE-1:0] pe_start, pe_busy;
   logic [NPE-1:0] pe_done = '0;
   logic [31:0] pe_split_addr, pe_key_addr, pe_oracle_addr;
   logic [23:0] pe_key_count;
   logic        done_valid;
   logic [7:0]  done_tag;
   logic [2:0]  done_pe;
   logic        done_pop = 1'b0;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   job_dispatch i_job_dispatch (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .ovf_flag(ovf_flag), .pe_start(pe_start), .pe_split_addr(pe_split_addr),
      .pe_key_addr(pe_key_addr), .pe_oracle_addr(pe_oracle_addr),
      .pe_key_count(pe_key_count), .pe_done(pe_done), .pe_busy(pe_busy),
      .done_valid(done_valid), .done_tag(done_tag), .done_pe(done_pe),
      .done_pop(done_pop)
   );

   typedef struct packed {
      logic [31:0] split;
      logic [31:0] keys;
      logic [31:0] oracle;
      logic [23:0] cnt;
      logic [7:0]  tag;
      logic [3:0]  exp_pe;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{32'h0000_1000, 32'h0010_0000, 32'h0800_0000, 24'd8192,   8'hA0, 4'd0},
      '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 24'hFF_FFFF, 8'hFF, 4'd1},
      '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 24'd0,      8'h00, 4'd2},
      '{32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_0F0F, 24'd1,      8'h33, 4'd3},
      '{32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'hC3C3_C3C3, 24'h80_0000, 8'h5C, 4'd4},
      '{32'h0000_0040, 32'h0000_0080, 32'h0000_00C0, 24'd64,     8'h7E, 4'd5}
   };

   // start log (observed at ports)
   int          nlog = 0;
   int          multi = 0;
   logic [2:0]  log_pe [32];
   logic [31:0] log_split [32];

   always @(posedge clk) begin
      if (rst_n) begin
         if ($countones(pe_start) > 1) multi++;
         for (int i = 0; i < NPE; i++) begin
            if (pe_start[i] && nlog < 32) begin
               log_pe[nlog]    = 3'(i);
               log_split[nlog] = pe_split_addr;
               nlog++;
            end
         end
      end
   end

   bit finished = 0;

   task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [31:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic job(input logic [31:0] s, input logic [31:0] k, input logic [31:0] o,
                      input logic [23:0] c, input logic [7:0] t);
      wr(3'd0, s); wr(3'd1, k); wr(3'd2, o); wr(3'd3, {8'h0, c}); wr(3'd4, {24'h0, t});
   endtask

   task automatic finish(input logic [NPE-1:0] m);
      @(negedge clk); pe_done = m;
      @(negedge clk); pe_done = '0;
   endtask

   task automatic pop();
      @(negedge clk); done_pop = 1'b1;
      @(negedge clk); done_pop = 1'b0;
   endtask

   initial begin
      #(4 * 20000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int n0;
      repeat (3) @(negedge clk);
      chk(pe_start == '0, "R9 start idle", 64'(pe_start), 0);
      chk(pe_busy == '0, "R9 busy clear", 64'(pe_busy), 0);
      chk(!done_valid, "R9 done empty", 64'(done_valid), 0);
      chk(!ovf_flag, "R9 ovf clear", 64'(ovf_flag), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R7: completion from idle PEs ignored
      finish('1);
      repeat (3) @(negedge clk);
      chk(!done_valid, "R7 idle done ignored", 64'(done_valid), 0);
      chk(pe_busy == '0, "R7 busy unchanged", 64'(pe_busy), 0);

      // R1: field writes alone start nothing
      wr(3'd0, 32'hDEAD_0000); wr(3'd1, 32'hDEAD_0001); wr(3'd2, 32'hDEAD_0002); wr(3'd3, 32'h0000_0099);
      repeat (4) @(negedge clk);
      chk(nlog == 0, "R1 no start from field writes", 64'(nlog), 0);
      chk(pe_busy == '0, "R1 no busy from field writes", 64'(pe_busy), 0);

      // vector table: R2 / R4
      foreach (VECS[v]) begin
         job(VECS[v].split, VECS[v].keys, VECS[v].oracle, VECS[v].cnt, VECS[v].tag);
         @(negedge clk);
         chk(pe_start == NPE'(1) << VECS[v].exp_pe, "R4 R2 start on lowest idle PE",
             64'(pe_start), 64'(NPE'(1) << VECS[v].exp_pe));
         chk(pe_split_addr == VECS[v].split, "R2 splitter addr", 64'(pe_split_addr), 64'(VECS[v].split));
         chk(pe_key_addr == VECS[v].keys, "R2 key addr", 64'(pe_key_addr), 64'(VECS[v].keys));
         chk(pe_oracle_addr == VECS[v].oracle, "R2 oracle addr", 64'(pe_oracle_addr), 64'(VECS[v].oracle));
         chk(pe_key_count == VECS[v].cnt, "R2 key count", 64'(pe_key_count), 64'(VECS[v].cnt));
         @(negedge clk);
         chk(pe_start == '0, "R2 single-cycle start", 64'(pe_start), 0);
      end
      chk(pe_busy == '1, "R5 all PEs busy", 64'(pe_busy), 64'(6'h3F));

      // fill job queue while all busy, then overflow
      n0 = nlog;
      for (int k = 0; k < 4; k++) job(32'h1000 + k, 32'h2000, 32'h3000, 24'd5, 8'h40 + 8'(k));
      repeat (2) @(negedge clk);
      chk(!ovf_flag, "R3 no overflow at depth", 64'(ovf_flag), 0);
      chk(nlog == n0, "R5 no start to busy PE", 64'(nlog), 64'(n0));
      job(32'h1004, 32'h2000, 32'h3000, 24'd5, 8'h44);
      @(negedge clk);
      chk(ovf_flag, "R3 overflow set", 64'(ovf_flag), 1);

      // single completion, reissue to freed PE
      finish(NPE'(1) << 3);
      @(negedge clk);
      chk(done_valid, "R6 record present", 64'(done_valid), 1);
      chk(done_pe == 3'd3, "R6 record PE", 64'(done_pe), 3);
      chk(done_tag == VECS[3].tag, "R6 record tag", 64'(done_tag), 64'(VECS[3].tag));
      repeat (3) @(negedge clk);
      chk(nlog == n0 + 1 && log_pe[n0] == 3'd3, "R4 reissue to PE3", 64'(log_pe[n0]), 3);
      chk(log_split[n0] == 32'h1000, "R8 first queued job", 64'(log_split[n0]), 64'h1000);
      pop();

      // simultaneous completion of PE1 and PE4
      finish((NPE'(1) << 1) | (NPE'(1) << 4));
      @(negedge clk);
      chk(done_valid && done_pe == 3'd1, "R6 same-cycle lower first", 64'(done_pe), 1);
      chk(done_tag == VECS[1].tag, "R6 PE1 tag", 64'(done_tag), 64'(VECS[1].tag));
      pop();
      chk(done_valid && done_pe == 3'd4, "R6 same-cycle second", 64'(done_pe), 4);
      chk(done_tag == VECS[4].tag, "R6 PE4 tag", 64'(done_tag), 64'(VECS[4].tag));
      pop();
      chk(!done_valid, "R6 queue drained", 64'(done_valid), 0);
      repeat (2) @(negedge clk);
      chk(nlog == n0 + 3, "R4 two reissues", 64'(nlog), 64'(n0 + 3));
      chk(log_pe[n0+1] == 3'd1 && log_split[n0+1] == 32'h1001, "R8 second job to PE1",
          64'(log_split[n0+1]), 64'h1001);
      chk(log_pe[n0+2] == 3'd4 && log_split[n0+2] == 32'h1002, "R8 third job to PE4",
          64'(log_split[n0+2]), 64'h1002);

      // finishing order beats PE index: PE5 then PE0
      finish(NPE'(1) << 5);
      repeat (3) @(negedge clk);
      finish(NPE'(1));
      repeat (2) @(negedge clk);
      chk(done_valid && done_pe == 3'd5, "R6 finish order first", 64'(done_pe), 5);
      chk(done_tag == VECS[5].tag, "R6 PE5 tag", 64'(done_tag), 64'(VECS[5].tag));
      pop();
      chk(done_valid && done_pe == 3'd0, "R6 finish order second", 64'(done_pe), 0);
      chk(done_tag == VECS[0].tag, "R6 PE0 tag", 64'(done_tag), 64'(VECS[0].tag));
      pop();
      repeat (3) @(negedge clk);
      chk(nlog == n0 + 4, "R3 dropped job never issued", 64'(nlog), 64'(n0 + 4));
      chk(log_pe[n0+3] == 3'd5 && log_split[n0+3] == 32'h1003, "R8 fourth job to PE5",
          64'(log_split[n0+3]), 64'h1003);
      chk(!pe_busy[0], "R5 PE0 idle after record", 64'(pe_busy[0]), 0);
      chk(ovf_flag, "R3 overflow sticky", 64'(ovf_flag), 1);
      chk(multi == 0, "R4 at most one start per cycle", 64'(multi), 0);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule